// File: doc/BRIEF.md
# Single-Wire Slave Reset and Presence Responder

This block is the slave-side front end for one open-drain data line. On every falling edge it restarts a cycle counter that measures how long the line stays low. When the line comes back high, the length of the low period decides what happened. A long low period is a bus reset. A shorter one is the start of a bit time slot, which later bit logic times from the slot-start strobe. The threshold for a reset depends on the current speed. The block keeps a standard/overdrive speed flag. Command logic may raise that flag with a one-cycle request. A reset may lower it again, depending on how long the reset lasted.

After a reset the block waits a presence-wait interval, counted from the cycle in which the line is seen high again. It then pulls the line low for a presence-low interval and lets a recovery interval pass. After that it reports ready. Every interval is a clock-cycle parameter with separate standard and overdrive values, and the speed in force after the reset selects the value. If the line falls during the presence wait, the sequence is abandoned. The block then waits for the next reset.

The block carries no data stream, so it has no valid/ready handshake. Every pin is a plain level or a one-cycle strobe, and nothing can be held back. `line_in` must already be synchronized to `clk`. `drive_low` controls an external open-drain pull-down.

Top module: `sw_reset_responder`

## Requirements
- R1: In reset, and in the cycles after reset until the first bus reset, `ready`, `drive_low`, `slot_start` and `od_mode` are 0.
- R2: At standard speed, a low period of at least `RST_STD_CYC` cycles is a bus reset. A shorter low period starts no presence pulse and leaves `ready` unchanged.
- R3: After a bus reset, `drive_low` goes high `PW+1` negative-edge samples after the release (`PW` cycles counted from the first cycle the line is sampled high) and stays high for exactly `PL` cycles. `PW` and `PL` are the values for the speed in force after the reset.
- R4: `ready` rises `PR` cycles after `drive_low` falls, and it is 0 from the bus reset until then.
- R5: While `ready` is 1, each falling edge of the line gives `slot_start` a one-cycle pulse in the cycle after the edge is sampled. No pulse occurs when `ready` is 0.
- R6: A one-cycle `od_req` sets `od_mode` in the next cycle only when `ready` is 1 and the line is high. Otherwise it has no effect.
- R7: A bus reset whose low period is `RST_STD_CYC` cycles or longer always leaves `od_mode` at 0.
- R8: In overdrive, a low period from `RST_OD_CYC` to `OD_KEEP_CYC` cycles is a bus reset that keeps `od_mode` at 1 and uses the overdrive presence timing.
- R9: In overdrive, a bus reset longer than `OD_KEEP_CYC` cycles returns `od_mode` to 0 and uses the standard presence timing.
- R10: In overdrive, a low period shorter than `RST_OD_CYC` cycles is a time slot and not a bus reset.
- R11: A falling edge during the presence wait cancels the presence pulse. `ready` stays 0 until a later bus reset completes a full presence sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | 1 | Synchronized level of the data line |
| od_req | input | 1 | One-cycle request from command logic to enter overdrive |
| drive_low | output | 1 | Enable for the open-drain pull-down (presence pulse) |
| ready | output | 1 | Post-reset window has expired; bit traffic may start |
| slot_start | output | 1 | One-cycle strobe at the start of a time slot |
| od_mode | output | 1 | 1 = overdrive timing in force |

## Verification
The bench tests low periods on each side of every threshold: one cycle below and at the standard reset length, and below, at, and just above the two overdrive limits. A design with an off-by-one compare would treat a slot as a reset here, or would leave overdrive in the wrong place. Presence timing is measured in cycles from the release at both speeds. A design that started the wait on the falling edge, or that picked the timing from the old speed, would show a shifted or mis-sized pulse. The bench also pulls the line low inside the presence wait and sends overdrive requests while the block is not ready or the line is low. A design that ignored the abort, or that accepted those requests, would drive a stray presence pulse or enter overdrive.

// File: rtl/sw_reset_pkg.sv
package sw_reset_pkg;
  typedef enum logic [2:0] {
    ST_LISTEN,
    ST_PD_WAIT,
    ST_PD_LOW,
    ST_PD_REC,
    ST_READY
  } sw_state_e;
endpackage

// File: rtl/sw_low_timer.sv
module sw_low_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_in,
  output logic             fall,
  output logic             rise,
  output logic [CNT_W-1:0] low_len
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic line_q;

  assign fall = line_q & ~line_in;
  assign rise = ~line_q & line_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q  <= 1'b1;
      low_len <= '0;
    end else begin
      line_q <= line_in;
      if (!line_in) begin
        if (fall)                 low_len <= CNT_W'(1);
        else if (low_len != CNT_MAX) low_len <= low_len + CNT_W'(1);
      end
    end
  end

  // R2
  low_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (low_len == CNT_W'(1)));
endmodule

// File: rtl/sw_speed_ctl.sv
module sw_speed_ctl #(
  parameter int CNT_W       = 8,
  parameter int RST_STD_CYC = 100,
  parameter int RST_OD_CYC  = 10,
  parameter int OD_KEEP_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  input  logic             classify_en,
  input  logic [CNT_W-1:0] low_len,
  input  logic             od_req,
  input  logic             od_allow,
  output logic             reset_evt,
  output logic             od_mode
);
  localparam logic [CNT_W-1:0] THR_STD = CNT_W'(RST_STD_CYC);
  localparam logic [CNT_W-1:0] THR_OD  = CNT_W'(RST_OD_CYC);
  localparam logic [CNT_W-1:0] KEEP_OD = CNT_W'(OD_KEEP_CYC);

  logic [CNT_W-1:0] thr;

  assign thr       = od_mode ? THR_OD : THR_STD;
  assign reset_evt = rise & classify_en & (low_len >= thr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      od_mode <= 1'b0;
    end else if (reset_evt) begin
      od_mode <= od_mode & (low_len <= KEEP_OD);
    end else if (od_req && od_allow) begin
      od_mode <= 1'b1;
    end
  end

  // R7
  long_reset_std_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_evt && low_len >= THR_STD) |=> !od_mode);

  // R6
  od_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (od_req && od_allow && !reset_evt) |=> od_mode);
endmodule

// File: rtl/sw_presence_seq.sv
module sw_presence_seq
  import sw_reset_pkg::*;
#(
  parameter int PW_STD = 60,
  parameter int PL_STD = 240,
  parameter int PR_STD = 40,
  parameter int PW_OD  = 8,
  parameter int PL_OD  = 24,
  parameter int PR_OD  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic reset_evt,
  input  logic fall,
  input  logic od_mode,
  output logic classify_en,
  output logic drive_low,
  output logic ready,
  output logic slot_start
);
  localparam int M1    = (PW_STD > PL_STD) ? PW_STD : PL_STD;
  localparam int M2    = (PR_STD > M1) ? PR_STD : M1;
  localparam int M3    = (PW_OD > PL_OD) ? PW_OD : PL_OD;
  localparam int M4    = (PR_OD > M3) ? PR_OD : M3;
  localparam int T_MAX = (M2 > M4) ? M2 : M4;
  localparam int TW    = $clog2(T_MAX + 1);

  sw_state_e state;
  logic [TW-1:0] cnt;
  logic [TW-1:0] wait_end, low_end, rec_end;

  assign wait_end = od_mode ? TW'(PW_OD - 1) : TW'(PW_STD - 1);
  assign low_end  = od_mode ? TW'(PL_OD - 1) : TW'(PL_STD - 1);
  assign rec_end  = od_mode ? TW'(PR_OD - 1) : TW'(PR_STD - 1);

  assign classify_en = (state == ST_LISTEN) || (state == ST_READY);
  assign drive_low   = (state == ST_PD_LOW);
  assign ready       = (state == ST_READY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_LISTEN;
      cnt        <= '0;
      slot_start <= 1'b0;
    end else begin
      slot_start <= fall && (state == ST_READY);
      case (state)
        ST_LISTEN, ST_READY: begin
          if (reset_evt) begin
            state <= ST_PD_WAIT;
            cnt   <= '0;
          end
        end
        ST_PD_WAIT: begin
          if (fall) begin
            state <= ST_LISTEN;
          end else if (cnt == wait_end) begin
            state <= ST_PD_LOW;
            cnt   <= '0;
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
        ST_PD_LOW: begin
          if (cnt == low_end) begin
            state <= ST_PD_REC;
            cnt   <= '0;
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
        ST_PD_REC: begin
          if (cnt == rec_end) begin
            state <= ST_READY;
            cnt   <= '0;
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
        default: state <= ST_LISTEN;
      endcase
    end
  end

  // R4
  reset_drops_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_evt |=> (!ready && !drive_low));

  // R4
  presence_end_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_low) |-> !ready);

  // R5
  slot_only_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start |-> ready);

  // R11
  abort_no_presence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_PD_WAIT) && fall) |=> !drive_low);
endmodule

// File: rtl/sw_reset_responder.sv
module sw_reset_responder #(
  parameter int RST_STD_CYC = 96000,
  parameter int RST_OD_CYC  = 9600,
  parameter int OD_KEEP_CYC = 16000,
  parameter int PW_STD      = 3000,
  parameter int PL_STD      = 12000,
  parameter int PR_STD      = 1000,
  parameter int PW_OD       = 400,
  parameter int PL_OD       = 1600,
  parameter int PR_OD       = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic od_req,
  output logic drive_low,
  output logic ready,
  output logic slot_start,
  output logic od_mode
);
  localparam int CNT_W = $clog2(RST_STD_CYC + 1);

  logic             fall, rise, reset_evt, classify_en, od_allow;
  logic [CNT_W-1:0] low_len;

  assign od_allow = ready & line_in & ~rise;

  sw_low_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .line_in(line_in),
    .fall(fall), .rise(rise), .low_len(low_len)
  );

  sw_speed_ctl #(
    .CNT_W(CNT_W), .RST_STD_CYC(RST_STD_CYC),
    .RST_OD_CYC(RST_OD_CYC), .OD_KEEP_CYC(OD_KEEP_CYC)
  ) u_speed (
    .clk(clk), .rst_n(rst_n), .rise(rise), .classify_en(classify_en),
    .low_len(low_len), .od_req(od_req), .od_allow(od_allow),
    .reset_evt(reset_evt), .od_mode(od_mode)
  );

  sw_presence_seq #(
    .PW_STD(PW_STD), .PL_STD(PL_STD), .PR_STD(PR_STD),
    .PW_OD(PW_OD), .PL_OD(PL_OD), .PR_OD(PR_OD)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .reset_evt(reset_evt), .fall(fall),
    .od_mode(od_mode), .classify_en(classify_en), .drive_low(drive_low),
    .ready(ready), .slot_start(slot_start)
  );
endmodule

// File: tb/sw_reset_responder_bench.sv
module sw_reset_responder_bench;
  localparam int RSTD = 40, ROD = 8, KEEP = 14;
  localparam int WS = 5, LS = 9, RS = 4, WO = 2, LO = 3, RO = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic od_req = 1'b0;
  logic line_in, drive_low, ready, slot_start, od_mode;
  int   n_tests = 0, n_fail = 0;
  bit   m_od = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;
  assign line_in = ~(m_low | drive_low);

  sw_reset_responder #(
    .RST_STD_CYC(RSTD), .RST_OD_CYC(ROD), .OD_KEEP_CYC(KEEP),
    .PW_STD(WS), .PL_STD(LS), .PR_STD(RS), .PW_OD(WO), .PL_OD(LO), .PR_OD(RO)
  ) u_sw_reset_responder (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .od_req(od_req),
    .drive_low(drive_low), .ready(ready), .slot_start(slot_start), .od_mode(od_mode)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit is_rst(bit od, int len);
    return len >= (od ? ROD : RSTD);
  endfunction

  function automatic bit next_od(bit od, int len);
    return od && (len <= KEEP);
  endfunction

  // observe a presence sequence after release; mode = speed after reset
  task automatic watch_presence(bit od);
    int first_d = 0, n_d = 0, first_r = 0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      if (drive_low) begin
        n_d++;
        if (first_d == 0) first_d = k;
      end
      if (ready && first_r == 0) first_r = k;
      if (first_d == 0 && ready) chk("R4 ready before presence", 1, 0);
    end
    chk("R3 presence start", first_d, (od ? WO : WS) + 1);
    chk("R3 presence length", n_d, od ? LO : LS);
    chk("R4 ready time", first_r, (od ? WO + LO + RO : WS + LS + RS) + 1);
  endtask

  task automatic do_low(int len);
    bit was_ready = ready;
    bit rs = is_rst(m_od, len);
    bit no = next_od(m_od, len);
    @(negedge clk);
    m_low = 1'b1;
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      if (i == 1) chk("R5 slot strobe", slot_start, was_ready);
      if (i == 2) chk("R5 slot one cycle", slot_start, 0);
    end
    m_low = 1'b0;
    if (rs) begin
      m_od = no;
      watch_presence(m_od);
      chk(len >= RSTD ? "R7 speed after long reset" :
          (no ? "R8 overdrive kept" : "R9 overdrive left"), od_mode, m_od);
    end else begin
      for (int k = 1; k <= 20; k++) begin
        @(negedge clk);
        if (drive_low) chk(m_od ? "R10 no presence" : "R2 no presence", 1, 0);
      end
      chk(m_od ? "R10 ready kept" : "R2 ready kept", ready, was_ready);
      chk("R2 speed unchanged", od_mode, m_od);
    end
  endtask

  task automatic pulse_od(bit expect_set);
    @(negedge clk);
    od_req = 1'b1;
    @(negedge clk);
    od_req = 1'b0;
    if (expect_set) m_od = 1'b1;
    chk("R6 od request", od_mode, m_od);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 ready", ready, 0);
    chk("R1 drive", drive_low, 0);
    chk("R1 od", od_mode, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 slot", slot_start, 0);
    pulse_od(1'b0);           // R6 not ready
    do_low(10);               // R2 short in listen
    chk("R1 still not ready", ready, 0);
    do_low(RSTD);             // R2 R3 R4
    do_low(3);                // R5 slot
    do_low(RSTD - 1);         // R2 boundary
    // R6 request while line low
    @(negedge clk);
    m_low = 1'b1;
    @(negedge clk);
    od_req = 1'b1;
    @(negedge clk);
    od_req = 1'b0;
    chk("R6 od while low ignored", od_mode, 0);
    m_low = 1'b0;
    repeat (3) @(negedge clk);
    pulse_od(1'b1);           // R6 accepted
    do_low(ROD - 1);          // R10
    do_low(ROD);              // R8
    do_low(KEEP);             // R8
    do_low(KEEP + 1);         // R9
    pulse_od(1'b1);
    do_low(RSTD + 5);         // R7
    // R11 abort during presence wait
    @(negedge clk);
    m_low = 1'b1;
    repeat (RSTD) @(negedge clk);
    m_low = 1'b0;
    @(negedge clk);
    m_low = 1'b1;
    repeat (3) @(negedge clk);
    m_low = 1'b0;
    for (int k = 1; k <= 30; k++) begin
      @(negedge clk);
      if (drive_low) chk("R11 presence after abort", 1, 0);
    end
    chk("R11 not ready after abort", ready, 0);
    do_low(RSTD);             // R11 recovery
    chk("R11 ready after new reset", ready, 1);
    for (int it = 0; it < 40; it++) begin
      if (ready && ($urandom % 3 == 0) && !m_od) pulse_od(1'b1);
      do_low(1 + int'($urandom % 50));
      if (!ready) do_low(RSTD);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule